// File: doc/BRIEF.md
# Zero-Cross Gated Volume and Mute Controller

This block decides when a requested audio volume and mute setting becomes the effective setting of an audio path. Requests arrive as a 3-bit coarse code, a 3-bit fine code and a mute flag. The block then publishes an effective attenuation in dB and an effective mute flag, which drive a gain stage outside the block.

When the zero-cross enable is low, requests take effect on the next clock edge. When it is high, a changed request is held back. It is committed only when the incoming stream of signed audio samples crosses zero, so that the gain step makes no audible click. A timeout forces a held change through if the signal never crosses zero, for example with a DC input.

A hardware mute input overrides the effective mute output at once and without a clock. A sticky status flag reports that a crossing has been seen while the gating was enabled. A read strobe clears this flag.

Top module: `zc_vol_ctrl`

## Requirements
- R1: `atten_db_o` equals 8 × coarse + fine of the applied setting. Coarse occupies bits [5:3] and fine occupies bits [2:0], which gives a range of 0 to 63 dB.
- R2: With `zc_en_i` low, the requested mute, coarse and fine values appear on the outputs after the next rising clock edge.
- R3: With `zc_en_i` high, the applied setting holds until a clock edge at which a valid sample forms a crossing. The setting is updated at that edge.
- R4: A valid sample is a crossing if it equals zero, or if its sign bit (MSB) differs from the sign bit of the previous valid sample. The first valid sample after reset counts only if it is zero.
- R5: Pending requests merge. The values committed at a crossing are the request present in that cycle.
- R6: While `hw_mute_i` is high, `mute_o` is 1 combinationally, whatever the gating state.
- R7: After reset, `mute_o` is 1, `atten_db_o` is 0 and `zc_status_o` is 0.
- R8: `zc_status_o` becomes 1 after an edge at which a crossing occurs while `zc_en_i` is high, and it stays set. A crossing seen with `zc_en_i` low does not set it.
- R9: `zc_status_o` is cleared at an edge where `zc_en_i` is low, or where `status_rd_i` is high with no new crossing.
- R10: With `zc_en_i` high and a change pending, the TMO_SAMPLES-th valid sample without a crossing forces the commit. A forced commit does not set the status flag.
- R11: Samples with `sample_vld_i` low neither cause a crossing nor change the stored previous sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coarse_i | input | 3 | Requested coarse attenuation code, 8 dB per step |
| fine_i | input | 3 | Requested fine attenuation code, 1 dB per step |
| mute_i | input | 1 | Requested mute |
| zc_en_i | input | 1 | Defer changes to the next zero crossing |
| hw_mute_i | input | 1 | Immediate override mute |
| sample_i | input | SAMPLE_W | Signed audio sample |
| sample_vld_i | input | 1 | Sample strobe |
| status_rd_i | input | 1 | Read strobe that clears the status flag |
| atten_db_o | output | 6 | Effective attenuation in dB |
| mute_o | output | 1 | Effective mute |
| zc_status_o | output | 1 | Sticky crossing-seen flag |

## Verification
A wrong stored previous sign moves the commit point by one or more valid samples. It shows on `atten_db_o` or `mute_o` at the first sample whose expected crossing is missed or falsely taken. A wrong timeout count makes a held change land one sample early or late, so it is visible within TMO_SAMPLES valid samples. A wrong status register shows in the cycle after the enable drops or a read is issued. Corruption of the applied setting is visible on the very next edge, because the outputs are the applied registers with no further stage.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int COARSE_W   = 3;
  localparam int FINE_W     = 3;
  localparam int ATT_W      = COARSE_W + FINE_W;
  localparam int COARSE_STEP_DB = 8;

  typedef struct packed {
    logic                mute;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } vol_set_t;
endpackage

// File: rtl/zcv_detect.sv
module zcv_detect #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  output logic                zc_hit_o
);
  logic prev_sign_q, have_prev_q;
  logic cur_sign;

  assign cur_sign = sample_i[SAMPLE_W-1];
  assign zc_hit_o = sample_vld_i &&
                    ((sample_i == '0) || (have_prev_q && (cur_sign != prev_sign_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sign_q <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (sample_vld_i) begin
      prev_sign_q <= cur_sign;
      have_prev_q <= 1'b1;
    end
  end

  // R11: stored sign only moves on a valid sample
  assert_sign_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(prev_sign_q));
endmodule

// File: rtl/zcv_timeout.sv
module zcv_timeout #(
  parameter int TMO_SAMPLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic sample_vld_i,
  input  logic zc_hit_i,
  output logic force_o
);
  localparam int CNT_W = (TMO_SAMPLES > 2) ? $clog2(TMO_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign force_o = pending_i && sample_vld_i && !zc_hit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cnt_q <= '0;
    else if (!pending_i || force_o || (sample_vld_i && zc_hit_i)) cnt_q <= '0;
    else if (sample_vld_i)                                cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_idle_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_i |=> cnt_q == '0);
endmodule

// File: rtl/zcv_apply.sv
module zcv_apply
  import zcv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vol_set_t req_i,
  input  logic     zc_en_i,
  input  logic     hw_mute_i,
  input  logic     zc_hit_i,
  input  logic     force_i,
  input  logic     status_rd_i,
  output logic     pending_o,
  output logic [ATT_W-1:0] atten_db_o,
  output logic     mute_o,
  output logic     zc_status_o
);
  vol_set_t app_q;
  logic     status_q;
  logic     commit;
  logic     past_q;

  assign pending_o = zc_en_i && (req_i != app_q);
  assign commit    = !zc_en_i || zc_hit_i || force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q    <= '{mute: 1'b1, coarse: '0, fine: '0};
      status_q <= 1'b0;
      past_q   <= 1'b0;
    end else begin
      past_q <= 1'b1;
      if (commit) app_q <= req_i;
      if (!zc_en_i)      status_q <= 1'b0;
      else if (zc_hit_i) status_q <= 1'b1;
      else if (status_rd_i) status_q <= 1'b0;
    end
  end

  assign atten_db_o  = ATT_W'(app_q.coarse) * ATT_W'(COARSE_STEP_DB) + ATT_W'(app_q.fine);
  assign mute_o      = app_q.mute | hw_mute_i;
  assign zc_status_o = status_q;

  always_comb begin
    if (rst_ni && hw_mute_i) assert_hw_mute_R6: assert (mute_o);
  end

  assert_direct_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_q && $past(!zc_en_i) |-> app_q == $past(req_i));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_q && $past(zc_en_i && !zc_hit_i && !force_i) |-> $stable(app_q));
  assert_status_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_q && $past(!zc_en_i) |-> !zc_status_o);
  assert_status_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_q && $past(zc_en_i && zc_hit_i) |-> zc_status_o);
endmodule

// File: rtl/zc_vol_ctrl.sv
module zc_vol_ctrl
  import zcv_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int TMO_SAMPLES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                mute_i,
  input  logic                zc_en_i,
  input  logic                hw_mute_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic                status_rd_i,
  output logic [ATT_W-1:0]    atten_db_o,
  output logic                mute_o,
  output logic                zc_status_o
);
  vol_set_t req;
  logic     zc_hit, tmo_force, pending;

  assign req = '{mute: mute_i, coarse: coarse_i, fine: fine_i};

  zcv_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
    .clk_i, .rst_ni, .sample_i, .sample_vld_i, .zc_hit_o(zc_hit)
  );

  zcv_timeout #(.TMO_SAMPLES(TMO_SAMPLES)) u_tmo (
    .clk_i, .rst_ni, .pending_i(pending), .sample_vld_i,
    .zc_hit_i(zc_hit), .force_o(tmo_force)
  );

  zcv_apply u_apply (
    .clk_i, .rst_ni, .req_i(req), .zc_en_i, .hw_mute_i,
    .zc_hit_i(zc_hit), .force_i(tmo_force), .status_rd_i,
    .pending_o(pending), .atten_db_o, .mute_o, .zc_status_o
  );
endmodule

// File: tb/sim_zc_vol_ctrl.sv
module sim_zc_vol_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic [2:0]  coarse = 0, fine = 0;
  logic        mute = 0, zc_en = 0, hw_mute = 0, vld = 0, rd = 0;
  logic [15:0] smp = 0;
  logic [5:0]  atten;
  logic        mute_o, status;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  zc_vol_ctrl #(.SAMPLE_W(16), .TMO_SAMPLES(8)) u0 (
    .clk_i(clk), .rst_ni, .coarse_i(coarse), .fine_i(fine), .mute_i(mute),
    .zc_en_i(zc_en), .hw_mute_i(hw_mute), .sample_i(smp), .sample_vld_i(vld),
    .status_rd_i(rd), .atten_db_o(atten), .mute_o, .zc_status_o(status)
  );

  typedef struct packed {
    logic en; logic rd; logic mu; logic [2:0] co; logic [2:0] fi;
    logic vld; logic [15:0] smp;
    logic emu; logic [5:0] eat; logic est;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL[NV] = '{
    '{0,0,0,3'd0,3'd0,0,16'h0000, 0,6'd0, 0},  // R2 unmute direct
    '{0,0,0,3'd2,3'd3,0,16'h0000, 0,6'd19,0},  // R1 R2
    '{0,0,0,3'd7,3'd7,0,16'h0000, 0,6'd63,0},  // R1 max
    '{1,0,0,3'd7,3'd7,1,16'd100,  0,6'd63,0},  // R4 first sample, no cross
    '{1,0,0,3'd1,3'd0,1,16'd200,  0,6'd63,0},  // R3 held
    '{1,0,0,3'd1,3'd0,0,16'hFFFB, 0,6'd63,0},  // R11 invalid neg ignored
    '{1,0,0,3'd2,3'd1,1,16'd300,  0,6'd63,0},  // R3 still held
    '{1,0,0,3'd2,3'd1,1,16'hFED4, 0,6'd17,1},  // R3 R5 R8 crossing
    '{1,0,1,3'd2,3'd1,1,16'hFFF6, 0,6'd17,1},  // R4 same sign
    '{1,0,1,3'd2,3'd1,1,16'h0000, 1,6'd17,1},  // R4 zero sample
    '{1,1,1,3'd2,3'd1,0,16'h0000, 1,6'd17,0},  // R9 read clears
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},  // R10 count 1
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},
    '{1,0,0,3'd0,3'd0,1,16'd50,   1,6'd17,0},  // R10 seventh
    '{1,0,0,3'd0,3'd0,1,16'd50,   0,6'd0, 0},  // R10 forced, no status
    '{1,0,0,3'd0,3'd0,1,16'hFFFF, 0,6'd0, 1},  // R8 cross, nothing pending
    '{0,0,0,3'd0,3'd0,0,16'h0000, 0,6'd0, 0},  // R9 enable low clears
    '{0,0,0,3'd0,3'd0,1,16'd1,    0,6'd0, 0},  // R8 cross with enable low
    '{1,0,0,3'd5,3'd0,0,16'h0000, 0,6'd0, 0}   // R3 pending, no sample
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R7 mute", {7'b0, mute_o}, 8'd1);
    chk("R7 atten", {2'b0, atten}, 8'd0);
    chk("R7 status", {7'b0, status}, 8'd0);
    rst_ni = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      zc_en = TBL[i].en; rd = TBL[i].rd; mute = TBL[i].mu;
      coarse = TBL[i].co; fine = TBL[i].fi; vld = TBL[i].vld; smp = TBL[i].smp;
      @(posedge clk); #1;
      chk($sformatf("vec%0d mute", i), {7'b0, mute_o}, {7'b0, TBL[i].emu});
      chk($sformatf("vec%0d atten", i), {2'b0, atten}, {2'b0, TBL[i].eat});
      chk($sformatf("vec%0d status", i), {7'b0, status}, {7'b0, TBL[i].est});
    end
    // R6: hardware mute acts without a clock edge, while a change is pending
    @(negedge clk); vld = 0; rd = 0;
    hw_mute = 1; #0.5;
    chk("R6 hw mute on", {7'b0, mute_o}, 8'd1);
    chk("R3 still pending", {2'b0, atten}, 8'd0);
    hw_mute = 0; #0.5;
    chk("R6 hw mute off", {7'b0, mute_o}, 8'd0);
    // R5: merge, only the latest request lands at the crossing
    @(negedge clk); coarse = 3'd6; fine = 3'd2; mute = 1;
    @(negedge clk); vld = 1; smp = 16'h8000; coarse = 3'd3; fine = 3'd4; mute = 0;
    @(posedge clk); #1;
    chk("R5 merged atten", {2'b0, atten}, 8'd28);
    chk("R5 merged mute", {7'b0, mute_o}, 8'd0);
    // R9: set wins over read in the same cycle
    @(negedge clk); smp = 16'd9; rd = 1;
    @(posedge clk); #1;
    chk("R9 set beats read", {7'b0, status}, 8'd1);
    // R7: reset mid-run
    @(negedge clk); vld = 0; rd = 0; rst_ni = 0; #0.5;
    chk("R7 re-reset mute", {7'b0, mute_o}, 8'd1);
    chk("R7 re-reset atten", {2'b0, atten}, 8'd0);
    chk("R7 re-reset status", {7'b0, status}, 8'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule